// File: doc/BRIEF.md
# Dual-CPU Interrupt Level Controller

This block merges a common set of interrupt sources into one encoded priority level for each of two processors. There are five sources: a system reset request, vertical blank, horizontal blank, a command request raised by a host, and a PWM timer tick. A reset request is held in a single pending bit that both processors see. Vertical blank, horizontal blank and PWM events are latched into per-processor pending bits. Each processor has its own 4-bit enable mask, and these three sources pass the mask only at the instant the event fires.

The command request works differently. The host writes a small command register that holds one bit per processor. A processor's command interrupt is pending whenever its command bit and its command-enable mask bit are both set. It therefore follows both registers as a level, not as an event.

Each processor writes its mask with a byte write to offset 0x01. It acknowledges sources with 16-bit writes to fixed clear offsets. It reads nothing back and sees only its level output. The level is twice the index of the highest pending bit, so reset wins over vertical blank, which wins over horizontal blank, then command, then PWM.

Top module: `dual_irq_level_ctrl`

## Requirements
- R1: After reset, both level outputs are 0, `hblank_en` is 0, and all masks, pending bits and command bits are 0.
- R2: A `trig_vres` pulse drives both levels to 14, whatever either mask holds. A 16-bit write (`cpu_wr_wide`=1) to offset 0x14 by either processor clears that shared bit.
- R3: Mask bit 3 enables vertical blank, bit 2 horizontal blank and bit 0 PWM. A `trig_vint`, `trig_hint` or `trig_pwm` pulse sets a processor's pending bit only if that mask bit is 1 in the cycle of the pulse. A pulse that is masked off is discarded and does not appear when the mask is enabled later.
- R4: Pending bit positions are PWM=3, command=4, horizontal blank=5, vertical blank=6 and reset=7. A processor's level is 2 × the index of its highest pending bit, so the levels are 6, 8, 10, 12 and 14. The level is 0 when nothing is pending.
- R5: An input sampled on a rising edge updates the pending, mask and command state on that edge. The level output reflects the change on the following rising edge.
- R6: Processor c has a command interrupt pending exactly while its mask bit 1 and command bit c are both 1. Clearing either bit removes the interrupt, and setting both again restores it.
- R7: A host write (`host_wr_en`) loads `host_wr_data[1:0]` into the command register. Bit 0 belongs to processor 0 and bit 1 to processor 1. The upper data bits are ignored.
- R8: A byte write (`cpu_wr_wide`=0) to offset 0x01 loads `cpu_wr_data[3:0]` into the mask of the processor named by `cpu_wr_sel`, and loads `cpu_wr_data[7]` into the shared `hblank_en`. Byte writes to any other offset change nothing.
- R9: 16-bit writes to offsets 0x16, 0x18 and 0x1c clear the writing processor's vertical blank, horizontal blank and PWM pending bits. The other processor's bits are untouched.
- R10: A 16-bit write to offset 0x1a clears the writing processor's own command register bit.
- R11: When a trigger and a clear of the same bit arrive in one cycle, the bit ends up set. When a host write and a 0x1a clear arrive together, the host value is stored. A mask written in the same cycle as a trigger does not gate that trigger; the old mask does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_vres | input | 1 | Reset request pulse (shared) |
| trig_vint | input | 1 | Vertical blank pulse |
| trig_hint | input | 1 | Horizontal blank pulse |
| trig_pwm | input | 1 | PWM timer pulse |
| host_wr_en | input | 1 | Host command register write strobe |
| host_wr_data | input | 8 | Host write data, low bits used |
| cpu_wr_en | input | 1 | Processor register write strobe |
| cpu_wr_sel | input | SEL_W | Index of the writing processor |
| cpu_wr_wide | input | 1 | 1 = 16-bit clear write, 0 = byte mask write |
| cpu_wr_addr | input | 8 | Register offset |
| cpu_wr_data | input | 8 | Processor write data |
| lvl_out | output | NCPU*LVL_W | Encoded level; processor c in bits [c*LVL_W +: LVL_W] |
| hblank_en | output | 1 | Shared horizontal-blank enable flag |

## Verification
The assertions assume that trigger pulses and writes are synchronous to `clk` and that only one processor writes in any cycle, since `cpu_wr_sel` names a single writer. They also assume that a reset-level check is not overtaken by a new reset pulse within its two-cycle window. The random stimulus drives every input from the bench between clock edges and issues at most one processor write per cycle. It draws the write offsets mostly from the decoded set {0x01, 0x14, 0x16, 0x18, 0x1a, 0x1c}, plus one undecoded offset. Directed cases cover the collisions of a trigger with its clear, of a host write with a 0x1a clear, and of a mask write with a trigger.

// File: rtl/irqlvl_pkg.sv
package irqlvl_pkg;
   localparam int PEND_W   = 8;
   localparam int MASK_W   = 4;
   localparam int MASK_OFS = 3;   // mask bit n gates pending bit n+MASK_OFS
   localparam int BIT_PWM  = 3;
   localparam int BIT_CMD  = 4;
   localparam int BIT_HINT = 5;
   localparam int BIT_VINT = 6;
   localparam int BIT_VRES = 7;
   localparam logic [7:0] OFS_MASK     = 8'h01;
   localparam logic [7:0] OFS_CLR_VRES = 8'h14;
   localparam logic [7:0] OFS_CLR_VINT = 8'h16;
   localparam logic [7:0] OFS_CLR_HINT = 8'h18;
   localparam logic [7:0] OFS_CLR_CMD  = 8'h1a;
   localparam logic [7:0] OFS_CLR_PWM  = 8'h1c;
endpackage

// File: rtl/irqlvl_prio_enc.sv
module irqlvl_prio_enc #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 4
) (
   input  logic [IN_W-1:0]  vec,
   output logic [OUT_W-1:0] lvl
);
   initial begin
      if (2 * (IN_W - 1) >= (1 << OUT_W))
         $fatal(1, "irqlvl_prio_enc: OUT_W too narrow for IN_W");
   end

   always_comb begin
      lvl = '0;
      for (int i = 1; i < IN_W; i++) begin
         if (vec[i]) lvl = OUT_W'(2 * i);
      end
   end
endmodule

// File: rtl/irqlvl_cpu_slice.sv
module irqlvl_cpu_slice
   import irqlvl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_vint,
   input  logic              trig_hint,
   input  logic              trig_pwm,
   input  logic              mask_we,
   input  logic [MASK_W-1:0] mask_din,
   input  logic              clr_vint,
   input  logic              clr_hint,
   input  logic              clr_pwm,
   input  logic              cmd_req,
   output logic [MASK_W-1:0] mask_q,
   output logic [PEND_W-1:0] pend_vec
);
   logic vint_q, hint_q, pwm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         vint_q <= 1'b0;
         hint_q <= 1'b0;
         pwm_q  <= 1'b0;
      end else begin
         if (mask_we) mask_q <= mask_din;
         if (trig_vint && mask_q[BIT_VINT-MASK_OFS]) vint_q <= 1'b1;
         else if (clr_vint)                          vint_q <= 1'b0;
         if (trig_hint && mask_q[BIT_HINT-MASK_OFS]) hint_q <= 1'b1;
         else if (clr_hint)                          hint_q <= 1'b0;
         if (trig_pwm && mask_q[BIT_PWM-MASK_OFS])   pwm_q  <= 1'b1;
         else if (clr_pwm)                           pwm_q  <= 1'b0;
      end
   end

   always_comb begin
      pend_vec           = '0;
      pend_vec[BIT_PWM]  = pwm_q;
      pend_vec[BIT_CMD]  = mask_q[BIT_CMD-MASK_OFS] & cmd_req;
      pend_vec[BIT_HINT] = hint_q;
      pend_vec[BIT_VINT] = vint_q;
   end
endmodule

// File: rtl/dual_irq_level_ctrl.sv
module dual_irq_level_ctrl
   import irqlvl_pkg::*;
#(
   parameter int NCPU  = 2,
   parameter int LVL_W = 4,
   parameter int SEL_W = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trig_vres,
   input  logic                  trig_vint,
   input  logic                  trig_hint,
   input  logic                  trig_pwm,
   input  logic                  host_wr_en,
   input  logic [7:0]            host_wr_data,
   input  logic                  cpu_wr_en,
   input  logic [SEL_W-1:0]      cpu_wr_sel,
   input  logic                  cpu_wr_wide,
   input  logic [7:0]            cpu_wr_addr,
   input  logic [7:0]            cpu_wr_data,
   output logic [NCPU*LVL_W-1:0] lvl_out,
   output logic                  hblank_en
);
   initial begin
      if (NCPU < 1 || NCPU > 8)
         $fatal(1, "dual_irq_level_ctrl: NCPU must be 1..8");
      if ((1 << SEL_W) < NCPU)
         $fatal(1, "dual_irq_level_ctrl: SEL_W too narrow");
      if (2 * (PEND_W - 1) >= (1 << LVL_W))
         $fatal(1, "dual_irq_level_ctrl: LVL_W too narrow");
   end

   logic                              vres_q;
   logic [NCPU-1:0]                   cmd_q;
   logic                              hen_q;
   logic                              byte_wr, wide_wr, clr_vres;
   logic [NCPU-1:0]                   mask_we, cmd_clr;
   logic [NCPU-1:0][MASK_W-1:0]       mask_all;
   logic [NCPU-1:0][PEND_W-1:0]       pend_all;
   logic [NCPU-1:0][LVL_W-1:0]        lvl_q;

   assign byte_wr  = cpu_wr_en & ~cpu_wr_wide;
   assign wide_wr  = cpu_wr_en & cpu_wr_wide;
   assign clr_vres = wide_wr & (cpu_wr_addr == OFS_CLR_VRES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vres_q <= 1'b0;
         cmd_q  <= '0;
         hen_q  <= 1'b0;
      end else begin
         if (trig_vres)     vres_q <= 1'b1;
         else if (clr_vres) vres_q <= 1'b0;
         if (host_wr_en) cmd_q <= host_wr_data[NCPU-1:0];
         else            cmd_q <= cmd_q & ~cmd_clr;
         if (|mask_we) hen_q <= cpu_wr_data[7];
      end
   end

   assign hblank_en = hen_q;

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic              hit;
      logic [PEND_W-1:0] merged;
      logic [LVL_W-1:0]  lvl_d;

      assign hit        = (cpu_wr_sel == SEL_W'(c));
      assign mask_we[c] = byte_wr & hit & (cpu_wr_addr == OFS_MASK);
      assign cmd_clr[c] = wide_wr & hit & (cpu_wr_addr == OFS_CLR_CMD);

      irqlvl_cpu_slice u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .trig_vint(trig_vint),
         .trig_hint(trig_hint),
         .trig_pwm (trig_pwm),
         .mask_we  (mask_we[c]),
         .mask_din (cpu_wr_data[MASK_W-1:0]),
         .clr_vint (wide_wr & hit & (cpu_wr_addr == OFS_CLR_VINT)),
         .clr_hint (wide_wr & hit & (cpu_wr_addr == OFS_CLR_HINT)),
         .clr_pwm  (wide_wr & hit & (cpu_wr_addr == OFS_CLR_PWM)),
         .cmd_req  (cmd_q[c]),
         .mask_q   (mask_all[c]),
         .pend_vec (pend_all[c])
      );

      assign merged = pend_all[c] | (PEND_W'(vres_q) << BIT_VRES);

      irqlvl_prio_enc #(.IN_W(PEND_W), .OUT_W(LVL_W)) u_enc (
         .vec(merged),
         .lvl(lvl_d)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) lvl_q[c] <= '0;
         else        lvl_q[c] <= lvl_d;
      end

      assign lvl_out[c*LVL_W +: LVL_W] = lvl_q[c];
   end
endmodule

// File: rtl/irqlvl_chk.sv
module irqlvl_chk
   import irqlvl_pkg::*;
#(
   parameter int NCPU  = 2,
   parameter int LVL_W = 4,
   parameter int SEL_W = 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        trig_vres,
   input logic                        trig_vint,
   input logic                        trig_hint,
   input logic                        trig_pwm,
   input logic                        host_wr_en,
   input logic [7:0]                  host_wr_data,
   input logic                        cpu_wr_en,
   input logic [SEL_W-1:0]            cpu_wr_sel,
   input logic                        cpu_wr_wide,
   input logic [7:0]                  cpu_wr_addr,
   input logic [NCPU*LVL_W-1:0]       lvl_out,
   input logic                        hblank_en,
   input logic [NCPU-1:0]             cmd_q,
   input logic [NCPU-1:0][MASK_W-1:0] mask_all,
   input logic [NCPU-1:0][PEND_W-1:0] pend_all
);
   assert_hen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr_en && !cpu_wr_wide && cpu_wr_addr == OFS_MASK) |=> $stable(hblank_en));

   assert_host_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en |=> (cmd_q == $past(host_wr_data[NCPU-1:0])));

   for (genvar c = 0; c < NCPU; c++) begin : g_c
      assert_vres_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
         trig_vres |-> ##2 (lvl_out[c*LVL_W +: LVL_W] == LVL_W'(14)));

      assert_level_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_out[c*LVL_W] == 1'b0);

      assert_hint_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_all[c][BIT_HINT]) |-> $past(trig_hint && mask_all[c][BIT_HINT-MASK_OFS]));

      assert_vint_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_all[c][BIT_VINT]) |-> $past(trig_vint && mask_all[c][BIT_VINT-MASK_OFS]));

      assert_pwm_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_all[c][BIT_PWM]) |-> $past(trig_pwm && mask_all[c][BIT_PWM-MASK_OFS]));

      assert_hint_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_wr_en && cpu_wr_wide && cpu_wr_addr == OFS_CLR_HINT &&
          cpu_wr_sel == SEL_W'(c) && !trig_hint) |=> !pend_all[c][BIT_HINT]);

      assert_cmd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_wr_en && cpu_wr_wide && cpu_wr_addr == OFS_CLR_CMD &&
          cpu_wr_sel == SEL_W'(c) && !host_wr_en) |=> !cmd_q[c]);

      assert_cmd_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr_en && host_wr_data[c] && mask_all[c][BIT_CMD-MASK_OFS] &&
          !(cpu_wr_en && !cpu_wr_wide && cpu_wr_addr == OFS_MASK && cpu_wr_sel == SEL_W'(c)))
         |=> pend_all[c][BIT_CMD]);
   end
endmodule

bind dual_irq_level_ctrl irqlvl_chk #(.NCPU(NCPU), .LVL_W(LVL_W), .SEL_W(SEL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trig_vres   (trig_vres),
   .trig_vint   (trig_vint),
   .trig_hint   (trig_hint),
   .trig_pwm    (trig_pwm),
   .host_wr_en  (host_wr_en),
   .host_wr_data(host_wr_data),
   .cpu_wr_en   (cpu_wr_en),
   .cpu_wr_sel  (cpu_wr_sel),
   .cpu_wr_wide (cpu_wr_wide),
   .cpu_wr_addr (cpu_wr_addr),
   .lvl_out     (lvl_out),
   .hblank_en   (hblank_en),
   .cmd_q       (cmd_q),
   .mask_all    (mask_all),
   .pend_all    (pend_all)
);

// File: tb/sim_dual_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_level_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_vres = 0, trig_vint = 0, trig_hint = 0, trig_pwm = 0;
   logic       host_wr_en = 0;
   logic [7:0] host_wr_data = 0;
   logic       cpu_wr_en = 0;
   logic [0:0] cpu_wr_sel = 0;
   logic       cpu_wr_wide = 0;
   logic [7:0] cpu_wr_addr = 0;
   logic [7:0] cpu_wr_data = 0;
   logic [7:0] lvl_out;
   logic       hblank_en;

   int n_chk = 0;
   int n_bad = 0;

   dual_irq_level_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .trig_vres(trig_vres), .trig_vint(trig_vint),
      .trig_hint(trig_hint), .trig_pwm(trig_pwm),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_sel(cpu_wr_sel),
      .cpu_wr_wide(cpu_wr_wide), .cpu_wr_addr(cpu_wr_addr),
      .cpu_wr_data(cpu_wr_data),
      .lvl_out(lvl_out), .hblank_en(hblank_en)
   );

   always #2.5 clk = ~clk;

   // reference model state
   bit       m_vres;
   bit [1:0] m_vint, m_hint, m_pwm, m_cmd;
   bit [3:0] m_mask [2];
   bit       m_hen;
   int       e_lvl [2];

   function automatic int ref_level(bit vr, bit vi, bit hi, bit cm, bit pw);
      if (vr) return 14;
      if (vi) return 12;
      if (hi) return 10;
      if (cm) return 8;
      if (pw) return 6;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle();
      trig_vres = 0; trig_vint = 0; trig_hint = 0; trig_pwm = 0;
      host_wr_en = 0; host_wr_data = 0;
      cpu_wr_en = 0; cpu_wr_sel = 0; cpu_wr_wide = 0; cpu_wr_addr = 0; cpu_wr_data = 0;
   endtask

   // one clock: model update at the edge, compare at the falling edge (R4, R5)
   task automatic tick();
      int nl [2];
      @(posedge clk);
      for (int c = 0; c < 2; c++)
         nl[c] = ref_level(m_vres, m_vint[c], m_hint[c], m_mask[c][1] & m_cmd[c], m_pwm[c]);
      if (!rst_n) begin
         m_vres = 0; m_vint = 0; m_hint = 0; m_pwm = 0; m_cmd = 0; m_hen = 0;
         m_mask[0] = 0; m_mask[1] = 0; nl[0] = 0; nl[1] = 0;
      end else begin
         bit [3:0] old_mask [2];
         old_mask[0] = m_mask[0]; old_mask[1] = m_mask[1];
         if (trig_vres) m_vres = 1;
         else if (cpu_wr_en && cpu_wr_wide && cpu_wr_addr == 8'h14) m_vres = 0;
         for (int c = 0; c < 2; c++) begin
            bit mine;
            mine = cpu_wr_en && cpu_wr_wide && (cpu_wr_sel == c[0:0]);
            if (trig_vint && old_mask[c][3]) m_vint[c] = 1;
            else if (mine && cpu_wr_addr == 8'h16) m_vint[c] = 0;
            if (trig_hint && old_mask[c][2]) m_hint[c] = 1;
            else if (mine && cpu_wr_addr == 8'h18) m_hint[c] = 0;
            if (trig_pwm && old_mask[c][0]) m_pwm[c] = 1;
            else if (mine && cpu_wr_addr == 8'h1c) m_pwm[c] = 0;
            if (host_wr_en) m_cmd[c] = host_wr_data[c];
            else if (mine && cpu_wr_addr == 8'h1a) m_cmd[c] = 0;
         end
         if (cpu_wr_en && !cpu_wr_wide && cpu_wr_addr == 8'h01) begin
            m_mask[cpu_wr_sel] = cpu_wr_data[3:0];
            m_hen = cpu_wr_data[7];
         end
      end
      e_lvl[0] = nl[0]; e_lvl[1] = nl[1];
      @(negedge clk);
      chk("R4 lvl0", int'(lvl_out[3:0]), e_lvl[0]);
      chk("R4 lvl1", int'(lvl_out[7:4]), e_lvl[1]);
      chk("R8 hen", int'(hblank_en), int'(m_hen));
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic cpu_write(bit sel, bit wide, logic [7:0] addr, logic [7:0] data);
      cpu_wr_en = 1; cpu_wr_sel = sel; cpu_wr_wide = wide;
      cpu_wr_addr = addr; cpu_wr_data = data;
      tick();
      idle();
   endtask

   task automatic host_write(logic [7:0] d);
      host_wr_en = 1; host_wr_data = d;
      tick();
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240613));
      idle();
      rst_n = 0;
      ticks(3);
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 lvl0", int'(lvl_out[3:0]), 0);
      chk("R1 lvl1", int'(lvl_out[7:4]), 0);
      chk("R1 hen", int'(hblank_en), 0);

      // R2 shared reset request ignores masks; R5 one-edge latency
      trig_vres = 1; tick(); idle();
      chk("R5 level not yet updated", int'(lvl_out[3:0]), 0);
      tick();
      chk("R2 lvl0", int'(lvl_out[3:0]), 14);
      chk("R2 lvl1", int'(lvl_out[7:4]), 14);
      cpu_write(1, 1, 8'h14, 8'h00); tick();
      chk("R2 cleared by 0x14", int'(lvl_out[3:0]), 0);

      // R3 masked trigger dropped, not held
      trig_hint = 1; tick(); idle(); tick();
      chk("R3 masked hint", int'(lvl_out[3:0]), 0);
      cpu_write(0, 0, 8'h01, 8'h04); ticks(2);
      chk("R3 dropped not held", int'(lvl_out[3:0]), 0);
      trig_hint = 1; tick(); idle(); tick();
      chk("R3 enabled hint cpu0", int'(lvl_out[3:0]), 10);
      chk("R3 masked hint cpu1", int'(lvl_out[7:4]), 0);

      // R9 clear belongs to the writer only
      cpu_write(1, 1, 8'h18, 8'h00); tick();
      chk("R9 other cpu untouched", int'(lvl_out[3:0]), 10);
      cpu_write(0, 1, 8'h18, 8'h00); tick();
      chk("R9 own hint cleared", int'(lvl_out[3:0]), 0);

      // R6 command is level-derived
      host_write(8'h03); tick();
      chk("R6 cmd gated by mask", int'(lvl_out[3:0]), 0);
      cpu_write(0, 0, 8'h01, 8'h02); tick();
      chk("R6 cmd appears", int'(lvl_out[3:0]), 8);
      cpu_write(0, 0, 8'h01, 8'h00); tick();
      chk("R6 cmd removed", int'(lvl_out[3:0]), 0);
      cpu_write(0, 0, 8'h01, 8'h02); tick();
      chk("R6 cmd restored", int'(lvl_out[3:0]), 8);

      // R7 only low two bits stored
      cpu_write(1, 0, 8'h01, 8'h02);
      host_write(8'hFD); tick();
      chk("R7 cpu0 bit", int'(lvl_out[3:0]), 8);
      chk("R7 cpu1 bit", int'(lvl_out[7:4]), 0);
      host_write(8'hFE); tick();
      chk("R7 cpu0 off", int'(lvl_out[3:0]), 0);
      chk("R7 cpu1 on", int'(lvl_out[7:4]), 8);

      // R10 own command bit clear
      cpu_write(1, 1, 8'h1a, 8'h00); tick();
      chk("R10 cmd cleared", int'(lvl_out[7:4]), 0);

      // R8 hen and ignored byte offset
      cpu_write(0, 0, 8'h01, 8'h8A);
      chk("R8 hen set", int'(hblank_en), 1);
      cpu_write(0, 0, 8'h02, 8'h00); tick();
      chk("R8 other offset ignored hen", int'(hblank_en), 1);

      // R11 trigger beats clear
      trig_vint = 1; cpu_wr_en = 1; cpu_wr_sel = 0; cpu_wr_wide = 1; cpu_wr_addr = 8'h16;
      tick(); idle(); tick();
      chk("R11 vint survives clear", int'(lvl_out[3:0]), 12);
      cpu_write(0, 1, 8'h16, 8'h00);
      // R11 host write beats 0x1a clear
      host_wr_en = 1; host_wr_data = 8'h01;
      cpu_wr_en = 1; cpu_wr_sel = 0; cpu_wr_wide = 1; cpu_wr_addr = 8'h1a;
      tick(); idle(); tick();
      chk("R11 host wins", int'(lvl_out[3:0]), 8);
      // R11 mask write same cycle as trigger uses old mask
      trig_vint = 1; cpu_wr_en = 1; cpu_wr_sel = 1; cpu_wr_wide = 0;
      cpu_wr_addr = 8'h01; cpu_wr_data = 8'h08;
      tick(); idle(); tick();
      chk("R11 old mask gates", int'(lvl_out[7:4]), 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         trig_vres = ($urandom % 32) == 0;
         trig_vint = ($urandom % 8) == 0;
         trig_hint = ($urandom % 8) == 0;
         trig_pwm  = ($urandom % 8) == 0;
         host_wr_en = ($urandom % 12) == 0;
         host_wr_data = 8'($urandom);
         cpu_wr_en = ($urandom % 3) == 0;
         cpu_wr_sel = 1'($urandom);
         cpu_wr_wide = 1'($urandom);
         case ($urandom % 7)
            0: cpu_wr_addr = 8'h01;
            1: cpu_wr_addr = 8'h14;
            2: cpu_wr_addr = 8'h16;
            3: cpu_wr_addr = 8'h18;
            4: cpu_wr_addr = 8'h1a;
            5: cpu_wr_addr = 8'h1c;
            default: cpu_wr_addr = 8'h02;
         endcase
         if (cpu_wr_addr == 8'h01 && ($urandom % 2) == 0) cpu_wr_wide = 0;
         cpu_wr_data = 8'($urandom);
         tick();
      end
      idle();
      ticks(4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule